// File: doc/BRIEF.md
# Randomized Background Check Scheduler

This block decides when a group of storage partitions must run their background checks. There are two kinds of check: an integrity pass and a consistency pass. Each kind starts on its own. It starts either when a pseudo-random interval expires or when a one-cycle software trigger arrives. When a pass starts, the block raises a request bit for every partition. It then waits while the partitions answer one by one with acknowledge bits. A shared response timeout guards the wait. Only one kind of pass is in flight at a time, and integrity wins when both are due.

The intervals come from a 40-bit LFSR that runs through a maximal-length Galois feedback. Each kind has a period mask. The LFSR state ANDed with that mask becomes the next countdown, so the mask bounds the interval. After a set number of LFSR steps, the block asks an entropy source for a fresh seed and holds the request until the source answers. The block enters a terminal error state in four cases:
- the response timeout expires;
- the LFSR locks up at zero;
- a countdown's shadow copy disagrees with it;
- the escalation input is asserted.

In that error state it reports a check-timeout flag.

Top module: `chk_sched`

## Requirements
- R1: After reset, all requests, `chk_pending_o`, `chk_timeout_o` and `ent_req_o` are 0. While `timer_en_i` is low the block starts no pass. A trigger seen in that time is remembered, and its pass starts two cycles after `timer_en_i` rises.
- R2: With the block idle, a one-cycle pulse on `integ_trig_i` sets all bits of `integ_req_o` two clock edges later. `cnsty_req_o` stays 0.
- R3: Bit i of an acknowledge vector clears bit i of the request vector of the same kind at the next edge. Other bits are left as they were.
- R4: `integ_req_o` and `cnsty_req_o` are never both nonzero. When both kinds are due together, the integrity pass runs first and the consistency pass follows once it is done.
- R5: When a kind's period mask is nonzero, that kind's passes start by themselves, without any trigger, at most mask+1 idle cycles after the previous one ends. When a kind's mask is zero, that kind never starts by itself.
- R6: When `timeout_i` = T is nonzero, a pass left unanswered drives `chk_timeout_o` high T+1 edges after its requests appear. At that edge all requests drop to 0.
- R7: When `timeout_i` is 0, a pass may wait without limit and never raises `chk_timeout_o`.
- R8: `esc_i` high at an edge sets `chk_timeout_o` at that edge from any state. The flag then stays set until reset, and triggers start no further pass.
- R9: `ent_req_o` rises once the LFSR has advanced RESEED_STEPS times since the last reseed. It stays high until `ent_ack_i` is seen, and it drops at the edge where the acknowledge is taken.
- R10: At the edge where `ent_req_o` and `ent_ack_i` are both high, `ent_data_i` becomes the LFSR state. A nonzero seed leaves the block working. A zero seed is a lock-up fault, and it sets `chk_timeout_o` one edge later.
- R11: A trigger that arrives while a pass of its own kind is waiting is held. A new pass of that kind starts after the current one ends.
- R12: `chk_pending_o` is high exactly while a pass is waiting, from the edge the requests appear until the edge after the last acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| timer_en_i | input | 1 | Lets the scheduler leave its reset state |
| esc_i | input | 1 | Escalation; forces the error state |
| integ_mask_i | input | W | Integrity period mask; 0 disables automatic passes |
| cnsty_mask_i | input | W | Consistency period mask; 0 disables automatic passes |
| timeout_i | input | W | Response timeout in cycles; 0 disables it |
| integ_trig_i | input | 1 | One-cycle request for an integrity pass |
| cnsty_trig_i | input | 1 | One-cycle request for a consistency pass |
| integ_ack_i | input | N_PART | Per-partition integrity acknowledge |
| cnsty_ack_i | input | N_PART | Per-partition consistency acknowledge |
| ent_ack_i | input | 1 | Entropy source answer |
| ent_data_i | input | W | New LFSR seed, taken with the acknowledge |
| integ_req_o | output | N_PART | Per-partition integrity request |
| cnsty_req_o | output | N_PART | Per-partition consistency request |
| chk_pending_o | output | 1 | A pass is waiting for acknowledges |
| chk_timeout_o | output | 1 | Terminal error flag |
| ent_req_o | output | 1 | Request for a fresh seed |

## Verification
The hardest situations to reach from the ports are the ones where two sources meet in the same cycle. The first is two due kinds at once. The second is a trigger arriving during a pass of its own kind. The third is a reseed whose data sends the LFSR into its lock-up state. The bench masks off all automatic passes so that each pass starts only on a trigger pulse placed exactly. It then pulses both triggers in one cycle, or re-pulses during a wait. To reach the lock-up state, it lets the step counter run until `ent_req_o` rises and answers with a zero seed. The delay from seed to error flag is the only way the LFSR's content shows at the ports.

// File: rtl/chk_sched_pkg.sv
`timescale 1ns/1ps
package chk_sched_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_IDLE  = 3'd1,
        ST_IWAIT = 3'd2,
        ST_CWAIT = 3'd3,
        ST_ERROR = 3'd4
    } sched_state_e;

    localparam int KIND_INTEG = 0;
    localparam int KIND_CNSTY = 1;
    localparam int NUM_KIND   = 2;

endpackage

// File: rtl/chk_sched_lfsr.sv
`timescale 1ns/1ps
module chk_sched_lfsr #(
    parameter int           W           = 40,
    parameter int           RESEED_STEPS = 256,
    parameter logic [W-1:0] SEED        = 40'h5A_5A12_34C3,
    parameter logic [W-1:0] TAPS        = 40'hA0_0014_0000
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         adv_i,
    input  logic         ent_ack_i,
    input  logic [W-1:0] ent_data_i,
    output logic [W-1:0] state_o,
    output logic         ent_req_o,
    output logic         err_o
);
    localparam int SW = $clog2(RESEED_STEPS + 1);
    localparam logic [SW-1:0] STEP_LIMIT = SW'(RESEED_STEPS);

    typedef struct packed {
        logic [W-1:0]  lfsr;
        logic [SW-1:0] steps;
        logic          req;
    } lfsr_regs_t;

    lfsr_regs_t q, d;
    logic       reseed;

    always_comb begin
        d      = q;
        reseed = q.req & ent_ack_i;
        if (reseed) begin
            d.lfsr  = ent_data_i;
            d.steps = '0;
            d.req   = 1'b0;
        end else begin
            if (adv_i) begin
                d.lfsr = {1'b0, q.lfsr[W-1:1]} ^ (q.lfsr[0] ? TAPS : '0);
            end
            if (adv_i && !q.req && q.steps != STEP_LIMIT) begin
                d.steps = q.steps + 1'b1;
            end
            if (q.steps == STEP_LIMIT) begin
                d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.lfsr  <= SEED;
            q.steps <= '0;
            q.req   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state_o   = q.lfsr;
    assign ent_req_o = q.req;
    assign err_o     = (q.lfsr == '0);

endmodule

// File: rtl/chk_sched_cdown.sv
`timescale 1ns/1ps
module chk_sched_cdown #(
    parameter int W = 40
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         err_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] shd;
    } cd_regs_t;

    cd_regs_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.cnt = load_val_i;
        end else if (dec_i && q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end
        d.shd = ~d.cnt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.cnt <= '0;
            q.shd <= '1;
        end else begin
            q <= d;
        end
    end

    assign cnt_o = q.cnt;
    assign err_o = (q.cnt != ~q.shd);

endmodule

// File: rtl/chk_sched.sv
`timescale 1ns/1ps
module chk_sched
    import chk_sched_pkg::*;
#(
    parameter int N_PART       = 4,
    parameter int W            = 40,
    parameter int RESEED_STEPS = 256
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              timer_en_i,
    input  logic              esc_i,
    input  logic [W-1:0]      integ_mask_i,
    input  logic [W-1:0]      cnsty_mask_i,
    input  logic [W-1:0]      timeout_i,
    input  logic              integ_trig_i,
    input  logic              cnsty_trig_i,
    input  logic [N_PART-1:0] integ_ack_i,
    input  logic [N_PART-1:0] cnsty_ack_i,
    input  logic              ent_ack_i,
    input  logic [W-1:0]      ent_data_i,
    output logic [N_PART-1:0] integ_req_o,
    output logic [N_PART-1:0] cnsty_req_o,
    output logic              chk_pending_o,
    output logic              chk_timeout_o,
    output logic              ent_req_o
);
    typedef struct packed {
        sched_state_e      state;
        logic [N_PART-1:0] int_req;
        logic [N_PART-1:0] con_req;
        logic              int_trig;
        logic              con_trig;
    } ctl_regs_t;

    ctl_regs_t q, d;

    logic [W-1:0]                  lfsr_state;
    logic                          lfsr_adv, lfsr_err;
    logic [NUM_KIND-1:0]           cd_load, cd_dec, cd_err, cd_zero, msk_zero;
    logic [NUM_KIND-1:0][W-1:0]    cd_val, cd_cnt, mask;
    logic                          due_int, due_con, tmo_off, fault;

    assign mask[KIND_INTEG] = integ_mask_i;
    assign mask[KIND_CNSTY] = cnsty_mask_i;

    chk_sched_lfsr #(
        .W            (W),
        .RESEED_STEPS (RESEED_STEPS)
    ) u_lfsr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .adv_i      (lfsr_adv),
        .ent_ack_i  (ent_ack_i),
        .ent_data_i (ent_data_i),
        .state_o    (lfsr_state),
        .ent_req_o  (ent_req_o),
        .err_o      (lfsr_err)
    );

    for (genvar k = 0; k < NUM_KIND; k++) begin : g_cd
        chk_sched_cdown #(.W(W)) u_cd (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .load_i     (cd_load[k]),
            .load_val_i (cd_val[k]),
            .dec_i      (cd_dec[k]),
            .cnt_o      (cd_cnt[k]),
            .err_o      (cd_err[k])
        );
        assign cd_zero[k]  = (cd_cnt[k] == '0);
        assign msk_zero[k] = (mask[k] == '0);
    end

    assign tmo_off = (timeout_i == '0);
    assign due_int = (!msk_zero[KIND_INTEG] && cd_zero[KIND_INTEG]) || q.int_trig;
    assign due_con = (!msk_zero[KIND_CNSTY] && cd_zero[KIND_CNSTY]) || q.con_trig;
    assign fault   = lfsr_err || (|cd_err) || esc_i;

    always_comb begin
        d        = q;
        cd_load  = '0;
        cd_dec   = '0;
        cd_val   = '0;
        lfsr_adv = 1'b0;
        d.int_trig = q.int_trig | integ_trig_i;
        d.con_trig = q.con_trig | cnsty_trig_i;

        unique case (q.state)
            ST_RESET: begin
                for (int k = 0; k < NUM_KIND; k++) begin
                    cd_load[k] = 1'b1;
                    cd_val[k]  = lfsr_state & mask[k];
                end
                if (timer_en_i) d.state = ST_IDLE;
            end
            ST_IDLE: begin
                lfsr_adv = 1'b1;
                if (due_int) begin
                    d.state              = ST_IWAIT;
                    d.int_req            = '1;
                    d.int_trig           = integ_trig_i;
                    cd_load[KIND_INTEG]  = 1'b1;
                    cd_val[KIND_INTEG]   = timeout_i;
                    cd_dec[KIND_CNSTY]   = 1'b1;
                end else if (due_con) begin
                    d.state              = ST_CWAIT;
                    d.con_req            = '1;
                    d.con_trig           = cnsty_trig_i;
                    cd_load[KIND_CNSTY]  = 1'b1;
                    cd_val[KIND_CNSTY]   = timeout_i;
                    cd_dec[KIND_INTEG]   = 1'b1;
                end else begin
                    cd_dec = '1;
                end
            end
            ST_IWAIT: begin
                lfsr_adv  = 1'b1;
                d.int_req = q.int_req & ~integ_ack_i;
                if (!tmo_off && cd_zero[KIND_INTEG]) begin
                    d.state = ST_ERROR;
                end else if (q.int_req == '0) begin
                    d.state             = ST_IDLE;
                    cd_load[KIND_INTEG] = 1'b1;
                    cd_val[KIND_INTEG]  = lfsr_state & mask[KIND_INTEG];
                end else begin
                    cd_dec[KIND_INTEG]  = 1'b1;
                end
            end
            ST_CWAIT: begin
                lfsr_adv  = 1'b1;
                d.con_req = q.con_req & ~cnsty_ack_i;
                if (!tmo_off && cd_zero[KIND_CNSTY]) begin
                    d.state = ST_ERROR;
                end else if (q.con_req == '0) begin
                    d.state             = ST_IDLE;
                    cd_load[KIND_CNSTY] = 1'b1;
                    cd_val[KIND_CNSTY]  = lfsr_state & mask[KIND_CNSTY];
                end else begin
                    cd_dec[KIND_CNSTY]  = 1'b1;
                end
            end
            ST_ERROR: begin
                d.state = ST_ERROR;
            end
            default: begin
                d.state = ST_ERROR;
            end
        endcase

        if (fault) d.state = ST_ERROR;
        if (d.state == ST_ERROR) begin
            d.int_req = '0;
            d.con_req = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state    <= ST_RESET;
            q.int_req  <= '0;
            q.con_req  <= '0;
            q.int_trig <= 1'b0;
            q.con_trig <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign integ_req_o   = q.int_req;
    assign cnsty_req_o   = q.con_req;
    assign chk_pending_o = (q.state == ST_IWAIT) || (q.state == ST_CWAIT);
    assign chk_timeout_o = (q.state == ST_ERROR);

endmodule

// File: rtl/chk_sched_chk.sv
`timescale 1ns/1ps
module chk_sched_chk #(
    parameter int N_PART = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              esc_i,
    input logic [N_PART-1:0] integ_req_o,
    input logic [N_PART-1:0] integ_ack_i,
    input logic [N_PART-1:0] cnsty_req_o,
    input logic [N_PART-1:0] cnsty_ack_i,
    input logic              chk_pending_o,
    input logic              chk_timeout_o,
    input logic              ent_req_o,
    input logic              ent_ack_i
);
    assert_integ_ack_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((integ_req_o & integ_ack_i) != '0) |=> ((integ_req_o & $past(integ_ack_i)) == '0));

    assert_cnsty_ack_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cnsty_req_o & cnsty_ack_i) != '0) |=> ((cnsty_req_o & $past(cnsty_ack_i)) == '0));

    assert_one_kind_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !((|integ_req_o) && (|cnsty_req_o)));

    assert_no_req_in_error_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_timeout_o |-> (integ_req_o == '0 && cnsty_req_o == '0));

    assert_esc_sets_error_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        esc_i |=> chk_timeout_o);

    assert_error_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_timeout_o |=> chk_timeout_o);

    assert_ent_req_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ent_req_o && !ent_ack_i) |=> ent_req_o);

    assert_ent_req_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ent_req_o && ent_ack_i) |=> !ent_req_o);

    assert_pending_covers_req_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|integ_req_o) || (|cnsty_req_o)) |-> chk_pending_o);

endmodule

bind chk_sched chk_sched_chk #(.N_PART(N_PART)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .esc_i         (esc_i),
    .integ_req_o   (integ_req_o),
    .integ_ack_i   (integ_ack_i),
    .cnsty_req_o   (cnsty_req_o),
    .cnsty_ack_i   (cnsty_ack_i),
    .chk_pending_o (chk_pending_o),
    .chk_timeout_o (chk_timeout_o),
    .ent_req_o     (ent_req_o),
    .ent_ack_i     (ent_ack_i)
);

// File: tb/sim_chk_sched.sv
`timescale 1ns/1ps
module sim_chk_sched;
    localparam int N  = 4;
    localparam int W  = 40;
    localparam int RS = 32;
    localparam logic [N-1:0] ALL = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic timer_en = 1'b0, esc = 1'b0;
    logic [W-1:0] imask = '0, cmask = '0, tmo = '0, edata = 40'h1;
    logic itrig = 1'b0, ctrig = 1'b0, eack = 1'b0;
    logic [N-1:0] iack = '0, cack = '0;
    logic [N-1:0] ireq, creq;
    logic pending, timeout, ereq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chk_sched #(.N_PART(N), .W(W), .RESEED_STEPS(RS)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .timer_en_i(timer_en), .esc_i(esc),
        .integ_mask_i(imask), .cnsty_mask_i(cmask), .timeout_i(tmo),
        .integ_trig_i(itrig), .cnsty_trig_i(ctrig),
        .integ_ack_i(iack), .cnsty_ack_i(cack),
        .ent_ack_i(eack), .ent_data_i(edata),
        .integ_req_o(ireq), .cnsty_req_o(creq),
        .chk_pending_o(pending), .chk_timeout_o(timeout), .ent_req_o(ereq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic en);
        rst_n = 1'b0; timer_en = en; esc = 1'b0; itrig = 1'b0; ctrig = 1'b0;
        iack = '0; cack = '0; eack = 1'b0; edata = 40'h1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic pulse_integ();
        itrig = 1'b1; tick(); itrig = 1'b0;
    endtask

    task automatic pulse_cnsty();
        ctrig = 1'b1; tick(); ctrig = 1'b0;
    endtask

    task automatic ack_integ(input logic [N-1:0] v);
        iack = v; tick(); iack = '0;
    endtask

    task automatic ack_cnsty(input logic [N-1:0] v);
        cack = v; tick(); cack = '0;
    endtask

    task automatic t_reset_hold();
        imask = '0; cmask = '0; tmo = '0;
        do_reset(1'b0);
        check("R1 reset req", {ireq, creq}, '0);
        check("R1 reset flags", {pending, timeout, ereq}, '0);
        pulse_integ();
        repeat (20) tick();
        check("R1 no pass while disabled", ireq, '0);
        check("R1 no pending while disabled", pending, 1'b0);
        timer_en = 1'b1;
        tick(); tick();
        check("R1 held trigger starts after enable", ireq, ALL);
        ack_integ(ALL);
    endtask

    task automatic t_trig_partial();
        imask = '0; cmask = '0; tmo = '0;
        do_reset(1'b1);
        tick(); tick();
        pulse_integ();
        tick();
        check("R2 integ requests all set", ireq, ALL);
        check("R2 cnsty requests idle", creq, '0);
        check("R12 pending in wait", pending, 1'b1);
        ack_integ(4'b0101);
        check("R3 partial ack clears own bits", ireq, 4'b1010);
        check("R12 pending after partial ack", pending, 1'b1);
        ack_integ(4'b1010);
        check("R3 all bits cleared", ireq, '0);
        check("R12 pending one edge after last ack", pending, 1'b1);
        tick();
        check("R12 pending falls", pending, 1'b0);
    endtask

    task automatic t_priority();
        bit seen = 1'b0;
        imask = '0; cmask = '0; tmo = '0;
        do_reset(1'b1);
        tick(); tick();
        itrig = 1'b1; ctrig = 1'b1; tick(); itrig = 1'b0; ctrig = 1'b0;
        tick();
        check("R4 integ wins", ireq, ALL);
        check("R4 cnsty waits", creq, '0);
        ack_integ(ALL);
        for (int i = 0; i < 6 && !seen; i++) begin
            tick();
            if (creq != '0) begin
                seen = 1'b1;
                check("R4 cnsty follows with all bits", creq, ALL);
                check("R4 integ quiet during cnsty", ireq, '0);
            end
        end
        check("R4 cnsty pass started", seen, 1'b1);
        ack_cnsty(ALL);
    endtask

    task automatic t_sticky();
        bit seen = 1'b0;
        imask = '0; cmask = '0; tmo = '0;
        do_reset(1'b1);
        tick(); tick();
        pulse_integ();
        tick();
        pulse_integ();
        ack_integ(ALL);
        for (int i = 0; i < 6 && !seen; i++) begin
            tick();
            if (ireq == ALL) seen = 1'b1;
        end
        check("R11 trigger during wait restarts pass", seen, 1'b1);
        ack_integ(ALL);
    endtask

    task automatic t_timeout();
        imask = '0; cmask = '0; tmo = 40'd10;
        do_reset(1'b1);
        tick(); tick();
        pulse_integ();
        repeat (11) tick();
        check("R6 no error before expiry", timeout, 1'b0);
        check("R6 requests still up", ireq, ALL);
        tick();
        check("R6 error at expiry", timeout, 1'b1);
        check("R6 requests dropped", ireq, '0);
    endtask

    task automatic t_no_timeout();
        imask = '0; cmask = '0; tmo = '0;
        do_reset(1'b1);
        tick(); tick();
        pulse_cnsty();
        repeat (200) tick();
        check("R7 no error with zero timeout", timeout, 1'b0);
        check("R7 still pending", pending, 1'b1);
        check("R7 cnsty requests held", creq, ALL);
    endtask

    task automatic t_periodic();
        bit stray = 1'b0;
        imask = '0; cmask = 40'h3; tmo = '0;
        do_reset(1'b1);
        for (int r = 0; r < 3; r++) begin
            bit seen = 1'b0;
            for (int i = 0; i < 12 && !seen; i++) begin
                tick();
                if (creq != '0) seen = 1'b1;
            end
            check("R5 automatic cnsty pass", seen, 1'b1);
            check("R5 no integ with zero mask", ireq, '0);
            if (r == 2) cmask = '0;
            ack_cnsty(ALL);
        end
        for (int i = 0; i < 100; i++) begin
            tick();
            if (ireq != '0 || creq != '0) stray = 1'b1;
        end
        check("R5 zero masks start nothing", stray, 1'b0);
    endtask

    task automatic t_escalate();
        imask = '0; cmask = '0; tmo = '0;
        do_reset(1'b1);
        tick(); tick();
        esc = 1'b1; tick(); esc = 1'b0;
        check("R8 escalation sets error", timeout, 1'b1);
        repeat (10) tick();
        check("R8 error sticky", timeout, 1'b1);
        pulse_integ();
        tick(); tick();
        check("R8 no pass after error", ireq, '0);
    endtask

    task automatic t_entropy();
        bit seen = 1'b0;
        imask = '0; cmask = '0; tmo = '0;
        do_reset(1'b1);
        repeat (20) tick();
        check("R9 no early entropy request", ereq, 1'b0);
        for (int i = 0; i < 40 && !seen; i++) begin
            tick();
            if (ereq) seen = 1'b1;
        end
        check("R9 entropy request raised", seen, 1'b1);
        repeat (10) tick();
        check("R9 request held without ack", ereq, 1'b1);
        edata = 40'h12_3456_789A; eack = 1'b1; tick(); eack = 1'b0;
        check("R9 request drops on ack", ereq, 1'b0);
        tick(); tick();
        check("R10 nonzero seed keeps working", timeout, 1'b0);
        seen = 1'b0;
        for (int i = 0; i < 50 && !seen; i++) begin
            tick();
            if (ereq) seen = 1'b1;
        end
        check("R9 second request after reseed", seen, 1'b1);
        edata = '0; eack = 1'b1; tick(); eack = 1'b0;
        tick();
        check("R10 zero seed locks up to error", timeout, 1'b1);
    endtask

    initial begin
        t_reset_hold();
        t_trig_partial();
        t_priority();
        t_sticky();
        t_timeout();
        t_no_timeout();
        t_periodic();
        t_escalate();
        t_entropy();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule